// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine with Complemented Transmit

This block keeps a 16-bit cyclic redundancy check over a byte stream. It uses the generator x^16 + x^15 + x^2 + 1. It protects reads of register pages and logged memory, and it gives a quick integrity check on scratchpad writes and reads. Each byte taken on the input stream updates the register in the same clock. The true register value is visible at all times on `crc_q`. An emit request sends the one's complement of the register over an output stream as two bytes. That complement is the form the CRC always takes on the wire.

The same engine also checks received data. The receiver feeds in the covered data, then the two complemented CRC bytes exactly as they arrived. When nothing was corrupted, the register settles on the fixed residue 0xB001, and `chk_ok` goes high. A clear input and a seed load set the register's starting point. Which bytes are covered, and when to emit, is left to the surrounding command logic.

Both data interfaces use valid/ready. An input byte is taken on any clock edge where `in_valid` and `in_ready` are both high. An output byte is delivered on any clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output holds its byte and its last flag. The engine applies back-pressure to the input by dropping `in_ready` for three reasons: while the two CRC bytes are being sent, while `clr` is high, and while `seed_load` is high.

Top module: `crc16_stream`

## Requirements
- R1: An accepted byte updates the register by processing its bits least significant first. The update uses the reflected feedback mask 0xA001. Starting from 0x0000, the ASCII bytes "123456789" give 0xBB3D on `crc_q` one clock after the last byte.
- R2: Reset (`rst_n` low) or `clr` high sets `crc_q` to 0x0000 at the next edge. `clr` takes priority over seed load and over input. It also cancels any emission in progress, so `out_valid` is low after that edge.
- R3: When `seed_load` is high and `clr` is low, `crc_q` takes `seed_val` at the next edge.
- R4: The register keeps its value on any edge with no accepted byte, no clear and no seed load.
- R5: An emit request accepted while idle sends the complement of the register as two bytes. The low byte (bits 7:0) goes first with `out_last` low. The high byte (bits 15:8) follows with `out_last` high. `out_valid` first goes high one clock after the request.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, with `out_data` and `out_last` unchanged.
- R7: `in_ready` is low while an emission is in progress, while `clr` is high and while `seed_load` is high. Bytes offered then are not taken and leave `crc_q` unchanged.
- R8: Emitting the CRC does not change `crc_q`.
- R9: A byte accepted on the same edge as an emit request is included in the value that is emitted.
- R10: `chk_ok` is high exactly when `crc_q` equals 0xB001. Feeding in data followed by its two emitted bytes, low byte first, raises `chk_ok`. Corrupting any of those bytes leaves it low.
- R11: An emit request while an emission is in progress is ignored. Exactly two bytes are sent, then `out_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Sets the register to 0x0000 and cancels emission |
| seed_load | input | 1 | Loads `seed_val` into the register |
| seed_val | input | 16 | Starting value for a seed load |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Engine can take an input byte |
| in_data | input | 8 | Input byte |
| emit_req | input | 1 | Request to send the complemented CRC |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer can take an output byte |
| out_data | output | 8 | Complemented CRC byte |
| out_last | output | 1 | Marks the second (high) CRC byte |
| crc_q | output | 16 | True (uninverted) register value |
| chk_ok | output | 1 | Register equals the check residue 0xB001 |

## Verification
The assertions check the control rules on every cycle. These are the clear and seed effects, the hold of the register when nothing is accepted, the stability of a stalled output byte, the input stall during emission, and the fixed low-then-high byte order. Only the bench's scenarios can show the arithmetic. That covers the known-vector result, the exact complemented byte values, whether a byte accepted together with an emit request is included, and whether the residue appears after a clean round trip but not after a corrupted one.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;
  localparam logic [CRC_W-1:0] RESIDUE   = 16'hB001;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc16_update.sv
// Unrolled byte update: one shift/feedback stage per data bit, LSB first.
module crc16_update #(
  parameter int unsigned         W    = 16,
  parameter int unsigned         DW   = 8,
  parameter logic [W-1:0]        POLY = 16'hA001
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  crc_o
);
  logic [DW:0][W-1:0] stage;

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb          = stage[i][0] ^ data_i[i];
    assign stage[i+1]  = (stage[i] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DW];
endmodule

// File: rtl/crc16_emitter.sv
// Serializes a snapshot word into DW-bit lanes, lowest lane first.
module crc16_emitter #(
  parameter int unsigned W  = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic [W-1:0]  word_i,
  output logic          busy_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  localparam int unsigned NB = W / DW;
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

  logic                   busy;
  logic [IW-1:0]          idx;
  logic [NB-1:0][DW-1:0]  lanes;
  logic                   last;

  assign last = (idx == IW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      lanes <= '0;
    end else if (abort_i) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start_i && !busy) begin
      busy  <= 1'b1;
      idx   <= '0;
      lanes <= word_i;
    end else if (busy && ready_i) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign busy_o  = busy;
  assign valid_o = busy;
  assign data_o  = lanes[idx];
  assign last_o  = busy && last;
endmodule

// File: rtl/crc16_stream.sv
module crc16_stream
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] CLR_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              seed_load,
  input  logic [CRC_W-1:0]  seed_val,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              emit_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic [CRC_W-1:0]  crc_q,
  output logic              chk_ok
);
  crc_t crc_r;
  crc_t crc_upd;
  crc_t crc_after;
  logic busy;
  logic take;
  logic start;

  assign in_ready  = !busy && !clr && !seed_load;
  assign take      = in_valid && in_ready;
  assign crc_after = take ? crc_upd : crc_r;
  assign start     = emit_req && !busy && !clr && !seed_load;

  crc16_update #(.W(CRC_W), .DW(BYTE_W), .POLY(POLY_REFL)) u_upd (
    .crc_i  (crc_r),
    .data_i (in_data),
    .crc_o  (crc_upd)
  );

  crc16_emitter #(.W(CRC_W), .DW(BYTE_W)) u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (clr),
    .start_i (start),
    .word_i  (~crc_after),
    .busy_o  (busy),
    .valid_o (out_valid),
    .ready_i (out_ready),
    .data_o  (out_data),
    .last_o  (out_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_r <= CLR_VAL;
    else if (clr)       crc_r <= CLR_VAL;
    else if (seed_load) crc_r <= seed_val;
    else if (take)      crc_r <= crc_upd;
  end

  assign crc_q  = crc_r;
  assign chk_ok = (crc_r == RESIDUE);
endmodule

// File: rtl/crc16_stream_chk.sv
module crc16_stream_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        seed_load,
  input logic [15:0] seed_val,
  input logic        in_valid,
  input logic        in_ready,
  input logic        emit_req,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [15:0] crc_q
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == 16'h0000) && !out_valid); // R2

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && !clr) |=> crc_q == $past(seed_val)); // R3

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !seed_load && !(in_valid && in_ready)) |=> $stable(crc_q)); // R4

  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_req && !out_valid && !clr && !seed_load) |=> out_valid && !out_last); // R5

  AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && !clr) |=> out_valid && out_last); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || clr || seed_load) |-> !in_ready); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !clr) |=> !out_valid); // R11
endmodule

bind crc16_stream crc16_stream_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .emit_req  (emit_req),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .crc_q     (crc_q)
);

// File: tb/crc16_stream_tb.sv
module crc16_stream_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed_val = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        emit_req = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_last;
  logic [15:0] crc_q;
  logic        chk_ok;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] model = '0;
  logic [8:0]  exp_q[$];

  always #5 clk = ~clk;

  crc16_stream u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .seed_load(seed_load), .seed_val(seed_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .emit_req(emit_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .crc_q(crc_q), .chk_ok(chk_ok)
  );

  // reference: x^16+x^15+x^2+1, reflected, LSB first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected output byte", {23'd0, out_last, out_data}, 32'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({out_last, out_data} === e, "R5 output byte/last", {23'd0, out_last, out_data}, {23'd0, e});
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    model = ref_crc(model, b);
  endtask

  task automatic push_emit(input logic [15:0] c);
    exp_q.push_back({1'b0, ~c[7:0]});
    exp_q.push_back({1'b1, ~c[15:8]});
  endtask

  task automatic emit();
    push_emit(model);
    @(posedge clk); #1; emit_req = 1'b1;
    @(posedge clk); #1; emit_req = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && (exp_q.size() != 0 || out_valid); k++) @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R5 emission completes", exp_q.size(), 0);
  endtask

  task automatic do_clr();
    @(posedge clk); #1; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
    model = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [15:0] snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(crc_q == 16'h0000, "R2 reset crc", crc_q, 0);
    check(!out_valid && in_ready, "R2 reset idle", {out_valid, in_ready}, 2'b01);

    // R1 known vector
    foreach (msg[i]) send_byte(msg[i]);
    @(negedge clk);
    check(crc_q == 16'hBB3D, "R1 check vector", crc_q, 16'hBB3D);
    check(crc_q == model, "R1 model match", crc_q, model);
    check(!chk_ok, "R10 no residue", chk_ok, 0);

    // R4 hold while idle
    repeat (5) @(negedge clk);
    check(crc_q == 16'hBB3D, "R4 hold idle", crc_q, 16'hBB3D);

    // R5 emission with ready high; expected bytes C2 then 44
    emit();
    drain();
    check(crc_q == 16'hBB3D, "R8 crc unchanged by emit", crc_q, 16'hBB3D);

    // R6/R7 back-pressure, input offered during emission
    out_ready = 1'b0;
    emit();
    @(posedge clk); #1; in_valid = 1'b1; in_data = 8'hA5;
    repeat (4) @(negedge clk);
    check(out_valid && out_data == 8'hC2 && !out_last, "R6 stalled byte held", {out_valid, out_last, out_data}, {2'b10, 8'hC2});
    check(!in_ready, "R7 in_ready low while emitting", in_ready, 0);
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(crc_q == 16'hBB3D, "R7 offered byte not taken", crc_q, 16'hBB3D);
    out_ready = 1'b1;
    drain();

    // R10 round trip residue
    send_byte(8'hC2);
    send_byte(8'h44);
    @(negedge clk);
    check(chk_ok && crc_q == 16'hB001, "R10 residue after clean trip", crc_q, 16'hB001);

    // R10 corrupted trip
    do_clr();
    foreach (msg[i]) send_byte(msg[i]);
    send_byte(8'hC3);
    send_byte(8'h44);
    @(negedge clk);
    check(!chk_ok, "R10 corrupted trip flagged", chk_ok, 0);

    // R3 seed load then update
    @(posedge clk); #1; seed_load = 1'b1; seed_val = 16'h1234;
    @(negedge clk);
    check(!in_ready, "R7 in_ready low on seed", in_ready, 0);
    @(posedge clk); #1; seed_load = 1'b0;
    model = 16'h1234;
    @(negedge clk);
    check(crc_q == 16'h1234, "R3 seed loaded", crc_q, 16'h1234);
    send_byte(8'h5A);
    send_byte(8'hFF);
    @(negedge clk);
    check(crc_q == model, "R1 update from seed", crc_q, model);

    // R9 byte accepted with the emit request
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'h00; emit_req = 1'b1;
    model = ref_crc(model, 8'h00);
    push_emit(model);
    @(posedge clk); #1; in_valid = 1'b0; emit_req = 1'b0;
    drain();
    check(crc_q == model, "R9 crc includes same-cycle byte", crc_q, model);

    // R11 repeated request during emission
    out_ready = 1'b0;
    emit();
    @(posedge clk); #1; emit_req = 1'b1;
    @(posedge clk); #1; emit_req = 1'b0;
    out_ready = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check(!out_valid, "R11 no extra emission", out_valid, 0);

    // R2 clear aborts emission
    out_ready = 1'b0;
    emit();
    @(posedge clk); #1; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
    model = '0;
    exp_q.delete();
    @(negedge clk);
    check(!out_valid && crc_q == 16'h0000, "R2 clear aborts emission", {out_valid, crc_q}, 17'h0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R2 nothing emitted after clear", out_valid, 0);

    finish_run();
  end
endmodule